// File: doc/BRIEF.md
# Fractal Tile Processor

This core decides, for a block of 32 columns by 16 rows of points on the complex plane, which points stay bounded under the iteration z ← z² + z + c. Software programs the tile's top-left coordinate, the constant c and an iteration-limit selector through a small register bus. It then writes a start command. The core walks every point of the tile, runs each one through a fixed-point escape unit that performs one iteration per cycle, and records one bit per point in sixteen 32-bit result words. When the last point is finished it sets a done flag.

All values use signed Q4.28 fixed point. Points in a tile are spaced 1/160 apart (0x0019_999A) on both axes. Columns move right with increasing real part. Rows move down with decreasing imaginary part, so twenty by thirty tiles cover a 640×480 picture of the region −2 ≤ Re < 2, −1.5 < Im ≤ 1.5.

Top module: `frac_tile_core`

## Requirements
- R1: After reset, every configuration register, every result word, the done flag and rdata_o read as zero.
- R2: A write (cs_i=1, we_i=1) to offsets 0, 1, 2 or 3 stores the 32-bit real start, imaginary start, c real and c imaginary value. A write to offset 4 stores only the low 3 bits as the limit selector. A read (cs_i=1, we_i=0) presents the addressed value on rdata_o in the following cycle. Offsets 0–4 read back their stored values, offset 6 returns done in bit 0, and offset 5 reads as zero.
- R3: A write to offset 5 with bit 0 set, while the core is idle, starts a tile. A write to offset 5 with bit 0 clear does nothing.
- R4: Starting a tile clears the done flag and all sixteen result words before any point is evaluated.
- R5: Point (row r, column k) starts from Re = z0x + k·0x0019_999A and Im = z0y − r·0x0019_999A, both taken modulo 2^32.
- R6: One iteration uses sx = (zx·zx)>>28 and sy = (zy·zy)>>28 on full signed products. The new zx is the low 32 bits of sx − sy + zx + cx. The new zy is the low 32 bits of ((zx·zy)>>27) + zy + cy.
- R7: A point escapes when sx + sy ≥ 4.0 (2^30) before any iteration or after any of the first L iterations, where L = ITER_BASE + ITER_STEP·selector (100 + 50·selector by default). A point that does not escape is a member.
- R8: Bit k of the word at offset 16 + r is 1 exactly when point (r, k) is a member.
- R9: Done (offset 6 bit 0) becomes 1 after the last point of the tile and stays 1 until the next accepted start.
- R10: While a tile is being computed, every bus write is ignored, including configuration writes and further start commands.
- R11: Result words at offsets 16–31 are read-only, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 5 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read |

## Verification
The bench builds the core with ITER_BASE=4 and ITER_STEP=2, so the limit runs from 4 to 18 iterations instead of 100 to 450. With these values a whole tile takes about ten thousand cycles. This lets the bench run several tiles at different c values and selectors, including a corner tile where every point escapes and a run where only the selector changes. Each result bit is compared against a bench model that follows R5–R7 in 64-bit integer arithmetic.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [1:0] {SC_IDLE, SC_LOAD, SC_WAIT} scan_state_e;

  localparam int unsigned OFF_Z0X  = 0;
  localparam int unsigned OFF_Z0Y  = 1;
  localparam int unsigned OFF_CX   = 2;
  localparam int unsigned OFF_CY   = 3;
  localparam int unsigned OFF_SEL  = 4;
  localparam int unsigned OFF_CTRL = 5;
  localparam int unsigned OFF_STAT = 6;
endpackage

// File: rtl/frac_escape.sv
module frac_escape #(
  parameter int DW   = 32,
  parameter int FRAC = 28,
  parameter int ITW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] re_i,
  input  logic [DW-1:0] im_i,
  input  logic [DW-1:0] cx_i,
  input  logic [DW-1:0] cy_i,
  input  logic [ITW-1:0] limit_i,
  output logic          valid_o,
  output logic          member_o
);
  localparam int PW = 2 * DW;
  localparam int SW = PW - FRAC;
  localparam logic [SW:0] ESC_LIM = (SW+1)'(1) << (FRAC + 2);

  logic signed [DW-1:0] zx_q, zy_q;
  logic [ITW-1:0] it_q;
  logic act_q;

  logic signed [PW-1:0] p_xx, p_yy, p_xy;
  logic [SW-1:0] sq_x, sq_y;
  logic [SW:0] mag;
  logic escaped, at_lim;
  logic [DW-1:0] nx, ny;

  assign p_xx = PW'(zx_q) * PW'(zx_q);
  assign p_yy = PW'(zy_q) * PW'(zy_q);
  assign p_xy = PW'(zx_q) * PW'(zy_q);
  assign sq_x = p_xx[PW-1:FRAC];
  assign sq_y = p_yy[PW-1:FRAC];
  // squares are non-negative, so a zero-extended sum is exact
  assign mag  = {1'b0, sq_x} + {1'b0, sq_y};
  assign escaped = mag >= ESC_LIM;
  assign at_lim  = it_q == limit_i;

  assign nx = sq_x[DW-1:0] - sq_y[DW-1:0] + zx_q + cx_i;
  assign ny = p_xy[DW+FRAC-2:FRAC-1] + zy_q + cy_i;

  assign valid_o  = act_q & (escaped | at_lim);
  assign member_o = ~escaped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zx_q  <= '0;
      zy_q  <= '0;
      it_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      zx_q  <= re_i;
      zy_q  <= im_i;
      it_q  <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (escaped || at_lim) begin
        act_q <= 1'b0;
      end else begin
        zx_q <= nx;
        zy_q <= ny;
        it_q <= it_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_scan.sv
module frac_scan #(
  parameter int DW   = 32,
  parameter int COLS = 32,
  parameter int ROWS = 16,
  parameter logic [DW-1:0] STEP = 'h0019_999A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] z0x_i,
  input  logic [DW-1:0] z0y_i,
  input  logic          valid_i,
  input  logic          member_i,
  output logic          load_o,
  output logic [DW-1:0] re_o,
  output logic [DW-1:0] im_o,
  output logic          busy_o,
  output logic          set_o,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic [$clog2(COLS)-1:0] col_o,
  output logic          tile_done_o
);
  import frac_pkg::*;
  localparam int COLW = $clog2(COLS);
  localparam int ROWW = $clog2(ROWS);
  localparam logic [COLW-1:0] COL_LAST = COLW'(COLS - 1);
  localparam logic [ROWW-1:0] ROW_LAST = ROWW'(ROWS - 1);

  scan_state_e st_q;
  logic [COLW-1:0] col_q;
  logic [ROWW-1:0] row_q;
  logic [DW-1:0] re_q, im_q;
  logic row_end, last_pt;

  assign row_end = col_q == COL_LAST;
  assign last_pt = row_end && (row_q == ROW_LAST);

  assign load_o      = st_q == SC_LOAD;
  assign busy_o      = st_q != SC_IDLE;
  assign re_o        = re_q;
  assign im_o        = im_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign set_o       = (st_q == SC_WAIT) && valid_i && member_i;
  assign tile_done_o = (st_q == SC_WAIT) && valid_i && last_pt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SC_IDLE;
      col_q <= '0;
      row_q <= '0;
      re_q  <= '0;
      im_q  <= '0;
    end else begin
      unique case (st_q)
        SC_IDLE: if (start_i) begin
          re_q  <= z0x_i;
          im_q  <= z0y_i;
          col_q <= '0;
          row_q <= '0;
          st_q  <= SC_LOAD;
        end
        SC_LOAD: st_q <= SC_WAIT;
        SC_WAIT: if (valid_i) begin
          if (last_pt) begin
            st_q <= SC_IDLE;
          end else begin
            st_q <= SC_LOAD;
            if (row_end) begin
              col_q <= '0;
              row_q <= row_q + 1'b1;
              re_q  <= z0x_i;  // config is frozen while busy
              im_q  <= im_q - STEP;
            end else begin
              col_q <= col_q + 1'b1;
              re_q  <= re_q + STEP;
            end
          end
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frac_regs.sv
module frac_regs #(
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int COLS = 32,
  parameter int ROWS = 16,
  parameter int SELW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          set_i,
  input  logic [$clog2(ROWS)-1:0] row_i,
  input  logic [$clog2(COLS)-1:0] col_i,
  input  logic          tile_done_i,
  output logic [DW-1:0] z0x_o,
  output logic [DW-1:0] z0y_o,
  output logic [DW-1:0] cx_o,
  output logic [DW-1:0] cy_o,
  output logic [SELW-1:0] sel_o,
  output logic          start_o,
  output logic          done_o
);
  import frac_pkg::*;
  localparam int ROWW = $clog2(ROWS);
  localparam int RES_BASE = (1 << AW) - ROWS;
  localparam logic [AW-1:0] A_Z0X  = AW'(OFF_Z0X);
  localparam logic [AW-1:0] A_Z0Y  = AW'(OFF_Z0Y);
  localparam logic [AW-1:0] A_CX   = AW'(OFF_CX);
  localparam logic [AW-1:0] A_CY   = AW'(OFF_CY);
  localparam logic [AW-1:0] A_SEL  = AW'(OFF_SEL);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_RES  = AW'(RES_BASE);

  logic [DW-1:0] z0x_q, z0y_q, cx_q, cy_q;
  logic [SELW-1:0] sel_q;
  logic done_q;
  logic [COLS-1:0] res_q [ROWS];
  logic wr_ok;
  logic [AW-1:0] res_off;
  logic [DW-1:0] rd_mux;

  assign wr_ok   = cs_i & we_i & ~busy_i;
  assign start_o = wr_ok && (addr_i == A_CTRL) && wdata_i[0];
  assign res_off = addr_i - A_RES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z0x_q <= '0;
      z0y_q <= '0;
      cx_q  <= '0;
      cy_q  <= '0;
      sel_q <= '0;
    end else if (wr_ok) begin
      unique case (addr_i)
        A_Z0X: z0x_q <= wdata_i;
        A_Z0Y: z0y_q <= wdata_i;
        A_CX:  cx_q  <= wdata_i;
        A_CY:  cy_q  <= wdata_i;
        A_SEL: sel_q <= wdata_i[SELW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      for (int r = 0; r < ROWS; r++) res_q[r] <= '0;
    end else if (start_o) begin
      done_q <= 1'b0;
      for (int r = 0; r < ROWS; r++) res_q[r] <= '0;
    end else begin
      if (set_i) res_q[row_i][col_i] <= 1'b1;
      if (tile_done_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i >= A_RES) begin
      rd_mux = DW'(res_q[res_off[ROWW-1:0]]);
    end else begin
      unique case (addr_i)
        A_Z0X:  rd_mux = z0x_q;
        A_Z0Y:  rd_mux = z0y_q;
        A_CX:   rd_mux = cx_q;
        A_CY:   rd_mux = cy_q;
        A_SEL:  rd_mux = DW'(sel_q);
        A_STAT: rd_mux = DW'(done_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (cs_i && !we_i) rdata_o <= rd_mux;
  end

  assign z0x_o  = z0x_q;
  assign z0y_o  = z0y_q;
  assign cx_o   = cx_q;
  assign cy_o   = cy_q;
  assign sel_o  = sel_q;
  assign done_o = done_q;
endmodule

// File: rtl/frac_tile_core.sv
module frac_tile_core #(
  parameter int DW        = 32,
  parameter int FRAC      = 28,
  parameter int COLS      = 32,
  parameter int ROWS      = 16,
  parameter int AW        = 5,
  parameter int SELW      = 3,
  parameter int ITER_BASE = 100,
  parameter int ITER_STEP = 50,
  parameter logic [DW-1:0] STEP = 'h0019_999A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int ITW  = $clog2(ITER_BASE + ITER_STEP * ((1 << SELW) - 1) + 1);
  localparam int COLW = $clog2(COLS);
  localparam int ROWW = $clog2(ROWS);

  logic [DW-1:0] z0x, z0y, cx, cy, re, im;
  logic [SELW-1:0] sel;
  logic [ITW-1:0] limit;
  logic start, busy, done, load, valid, member, set_bit, tile_done;
  logic [ROWW-1:0] row;
  logic [COLW-1:0] col;

  assign limit = ITW'(ITER_BASE) + ITW'(ITER_STEP) * ITW'(sel);

  frac_regs #(.DW(DW), .AW(AW), .COLS(COLS), .ROWS(ROWS), .SELW(SELW)) u_regs (
    .clk_i, .rst_ni, .cs_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .set_i(set_bit), .row_i(row), .col_i(col),
    .tile_done_i(tile_done), .z0x_o(z0x), .z0y_o(z0y), .cx_o(cx), .cy_o(cy),
    .sel_o(sel), .start_o(start), .done_o(done)
  );

  frac_scan #(.DW(DW), .COLS(COLS), .ROWS(ROWS), .STEP(STEP)) u_scan (
    .clk_i, .rst_ni, .start_i(start), .z0x_i(z0x), .z0y_i(z0y),
    .valid_i(valid), .member_i(member), .load_o(load), .re_o(re), .im_o(im),
    .busy_o(busy), .set_o(set_bit), .row_o(row), .col_o(col),
    .tile_done_o(tile_done)
  );

  frac_escape #(.DW(DW), .FRAC(FRAC), .ITW(ITW)) u_esc (
    .clk_i, .rst_ni, .load_i(load), .re_i(re), .im_i(im), .cx_i(cx), .cy_i(cy),
    .limit_i(limit), .valid_o(valid), .member_o(member)
  );
endmodule

// File: rtl/frac_tile_core_chk.sv
module frac_tile_core_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          load,
  input logic          valid,
  input logic [DW-1:0] z0x
);
  localparam logic [AW-1:0] A_STAT = AW'(frac_pkg::OFF_STAT);

  a_r4_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!done && busy));

  a_r3_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy);

  a_r9_done_means_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !busy);

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cs_i && we_i) |=> $stable(z0x));

  a_r2_status_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && addr_i == A_STAT) |=> (rdata_o[0] == $past(done)));

  a_r5_load_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load, valid}));
endmodule

bind frac_tile_core frac_tile_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .start(start), .busy(busy), .done(done), .load(load),
  .valid(valid), .z0x(z0x)
);

// File: tb/tb_frac_tile_core.sv
`timescale 1ns/1ps
module tb_frac_tile_core;
  localparam int IB = 4;
  localparam int IS = 2;
  localparam int STEP = 32'h0019_999A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int total = 0, bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frac_tile_core #(.ITER_BASE(IB), .ITER_STEP(IS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rdata;
  endtask

  // R6/R7 reference, 64-bit integer arithmetic
  function automatic bit model_pt(input int re, input int im, input int cx, input int cy, input int lim);
    int zx, zy;
    longint sx, sy, pxy;
    zx = re; zy = im;
    for (int it = 0; it <= lim; it++) begin
      sx = (longint'(zx) * longint'(zx)) >>> 28;
      sy = (longint'(zy) * longint'(zy)) >>> 28;
      if (sx + sy >= 64'sd1073741824) return 1'b0;
      if (it == lim) return 1'b1;
      pxy = longint'(zx) * longint'(zy);
      zx = int'(sx - sy + longint'(zx) + longint'(cx));
      zy = int'((pxy >>> 27) + longint'(zy) + longint'(cy));
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] model_row(input int zx0, input int zy0, input int cx, input int cy, input int sel, input int r);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 32; k++)
      w[k] = model_pt(int'(zx0 + k * STEP), int'(zy0 - r * STEP), cx, cy, IB + IS * sel);
    return w;
  endfunction

  task automatic wait_done(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 30000; i++) begin
      rd(5'd6, d);
      if (d[0]) return;
    end
    check({tag, " R9 done never set"}, 32'd0, 32'd1);
  endtask

  task automatic cfg(input int zx0, input int zy0, input int cx, input int cy, input int sel);
    wr(5'd0, zx0); wr(5'd1, zy0); wr(5'd2, cx); wr(5'd3, cy); wr(5'd4, sel);
  endtask

  task automatic check_rows(input string tag, input int zx0, input int zy0, input int cx, input int cy, input int sel);
    logic [31:0] d;
    for (int r = 0; r < 16; r++) begin
      rd(5'(16 + r), d);
      check($sformatf("%s R5 R8 row %0d", tag, r), d, model_row(zx0, zy0, cx, cy, sel, r));
    end
  endtask

  task automatic run_tile(input string tag, input int zx0, input int zy0, input int cx, input int cy, input int sel);
    logic [31:0] d;
    cfg(zx0, zy0, cx, cy, sel);
    wr(5'd5, 32'd1);
    rd(5'd6, d);
    check({tag, " R4 done cleared by start"}, d, 32'd0);
    wait_done(tag);
    check_rows(tag, zx0, zy0, cx, cy, sel);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata after reset", rdata, 32'd0);
    rd(5'd0, d);  check("R1 z0x reset", d, 32'd0);
    rd(5'd4, d);  check("R1 selector reset", d, 32'd0);
    rd(5'd6, d);  check("R1 done reset", d, 32'd0);
    rd(5'd16, d); check("R1 row 0 reset", d, 32'd0);
    rd(5'd31, d); check("R1 row 15 reset", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(5'd2, 32'hDEAD_BEEF); rd(5'd2, d); check("R2 cx readback", d, 32'hDEAD_BEEF);
    wr(5'd3, 32'h1234_5678); rd(5'd3, d); check("R2 cy readback", d, 32'h1234_5678);
    wr(5'd4, 32'hFFFF_FFFF); rd(5'd4, d); check("R2 selector 3 bits", d, 32'd7);
    rd(5'd5, d); check("R2 control reads zero", d, 32'd0);
    wr(5'd5, 32'd2);
    repeat (10) @(negedge clk);
    rd(5'd6, d); check("R3 bit0 clear does not start", d, 32'd0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    int zx0 = -161061274, zy0 = 80530637, cx = -134217728, cy = 134217728;
    cfg(zx0, zy0, cx, cy, 3);
    wr(5'd5, 32'd1);
    wr(5'd0, 32'd0);
    wr(5'd2, 32'h0100_0000);
    wr(5'd5, 32'd1);
    wait_done("ignore");
    rd(5'd0, d); check("R10 z0x write ignored while busy", d, zx0);
    rd(5'd2, d); check("R10 cx write ignored while busy", d, cx);
    check_rows("R10 results unaffected", zx0, zy0, cx, cy, 3);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, d); check("R11 result write ignored", d, model_row(zx0, zy0, cx, cy, 3, 0));
    repeat (50) @(negedge clk);
    rd(5'd6, d); check("R9 done holds", d, 32'd1);
    wr(5'd5, 32'd2);
    repeat (10) @(negedge clk);
    rd(5'd6, d); check("R3 bit0 clear keeps done", d, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    run_tile("cm1 sel7 R7", -26843546, 13421773, -268435456, 0, 7);
    run_tile("cm1 sel0 R7", -26843546, 13421773, -268435456, 0, 0);
    run_tile("c0 R6", -80530637, 40265318, 0, 0, 5);
    t_ignore();
    run_tile("corner R4 clears", -536870912, 402653184, -268435456, 0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule